// File: doc/BRIEF.md
# Multichannel Transmit Slot Selector

This block decides, slot by slot, what the transmit side of a time-division multiplexed serial port does with each channel of a frame of up to 128 channels. A slot counter inside the block goes back to channel 0 on a frame sync pulse and steps forward on every word strobe. At each of these slot boundaries the block looks up the channel that is starting. It uses a two-bit selection mode, a partition-mode bit, two partition block numbers, a per-channel receive-enable vector and four 32-bit enable registers. From these it produces two registered outputs. `tx_enable` tells the serializer to pull a word from the transmit buffer. `tx_mask` tells the pad to hold the data pin at high impedance for the whole slot.

Enabling and masking are two separate controls, and the mode decides how the enable bits drive each of them. In 128-channel mode every channel has its own enable bit. In 32-channel mode only register 0 is used, and its two halves serve two 16-channel blocks of the frame. The partition inputs choose which two blocks these are. Register writes take effect only at the next slot boundary.

Top module: `tx_slot_selector`

## Requirements
- R1: `frame_sync` high at a clock edge sets `slot_num` to 0. Otherwise, `word_strobe` high increments `slot_num` by one, and the count wraps from 127 to 0. `frame_sync` wins when both are high. A slot boundary is an edge where either input is high.
- R2: `slot_num`, `tx_enable` and `tx_mask` change only at slot boundaries. They are computed for the new channel from the enable registers as they stood before that edge, and from `mode`, `wide_mode`, `part_a_blk`, `part_b_blk` and `rx_chan_en` sampled at that edge. A register write in the same cycle as a boundary is seen only from the following boundary.
- R3: With `mode`=0, every channel gets `tx_enable`=1 and `tx_mask`=0, whatever the enable registers hold.
- R4: With `mode`=1, a channel whose select bit is 1 gets `tx_enable`=1 and `tx_mask`=0. A channel whose select bit is 0 gets `tx_enable`=0 and `tx_mask`=1.
- R5: With `mode`=2, `tx_enable`=1 for every channel, and `tx_mask` is the inverse of the select bit.
- R6: With `mode`=3, `tx_enable` equals `rx_chan_en[channel]`, and `tx_mask` is the inverse of the select bit, independent of the receive enable.
- R7: With `wide_mode`=1, the select bit for channel c is bit c mod 32 of register c div 32.
- R8: With `wide_mode`=0, only register 0 is used. If c div 16 equals `part_a_blk`, the select bit is register 0 bit (c mod 16). Otherwise, if c div 16 equals `part_b_blk`, it is register 0 bit 16+(c mod 16). A channel in neither block has select bit 0. Block A wins if both blocks are equal.
- R9: A write with `wr_en` stores `wr_data` into the register at `wr_addr` (0 to 3). `rd_data` returns the register at `rd_addr` without a clock edge. All registers reset to 0.
- R10: After reset, `slot_num`=0, `tx_enable`=0 and `tx_mask`=1 until the first slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Start of frame, restarts at channel 0 |
| word_strobe | input | 1 | Word boundary, advances to next channel |
| mode | input | 2 | Selection mode 0..3 |
| wide_mode | input | 1 | 1: 128 selectable channels, 0: 32 in two blocks |
| part_a_blk | input | 3 | 16-channel block served by register 0 bits 15:0 |
| part_b_blk | input | 3 | 16-channel block served by register 0 bits 31:16 |
| rx_chan_en | input | 128 | Per-channel receive enable, used in mode 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register read |
| rd_data | output | 32 | Read data |
| slot_num | output | 7 | Current channel |
| tx_enable | output | 1 | Take a word from the transmit buffer this slot |
| tx_mask | output | 1 | 1: data pin at high impedance this slot |

## Verification
The bench goes after the wrap from channel 127 to 0, and after a frame sync that arrives together with a word strobe. A wrong counter would run past the frame or resynchronize one slot late. It writes registers in the same cycle as a boundary and in mid-slot. A design that applied writes at once would change the outputs mid-slot or one slot early. In 32-channel mode it uses partition blocks that miss the current channel, and both blocks set equal. A wrong mapping would select channels outside the two blocks or index the wrong half of register 0. Mode 3 is driven with receive and transmit bits that disagree, which exposes a design that merges enable and mask.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
    typedef enum logic [1:0] {
        TXM_OPEN     = 2'd0,
        TXM_GATED    = 2'd1,
        TXM_MASKSEL  = 2'd2,
        TXM_RXFOLLOW = 2'd3
    } txm_e;

    typedef struct packed {
        logic en;
        logic mask;
    } slot_out_t;
endpackage

// File: rtl/txsel_regbank.sv
module txsel_regbank #(
    parameter int NREG = 4,
    parameter int RW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [RW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [RW-1:0]      rd_data,
    output logic [NREG*RW-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [RW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && (wr_addr == AW'(g))) word_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign regs_flat[g*RW +: RW] = word_q;
    end

    assign rd_data = regs_flat[rd_addr*RW +: RW];
endmodule

// File: rtl/txsel_slot_ctr.sv
module txsel_slot_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    input  logic          word_strobe,
    output logic          adv,
    output logic [CW-1:0] slot_nxt,
    output logic [CW-1:0] slot_q
);
    logic [CW-1:0] slot_d;

    always_comb begin
        adv      = frame_sync | word_strobe;
        slot_nxt = frame_sync ? '0 : slot_q + 1'b1;
        slot_d   = adv ? slot_nxt : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/txsel_chan_map.sv
module txsel_chan_map #(
    parameter int NREG  = 4,
    parameter int RW    = 32,
    parameter int SUB_W = 16,
    localparam int CHANS = NREG * RW,
    localparam int CW    = $clog2(CHANS),
    localparam int SW    = $clog2(SUB_W),
    localparam int BW    = CW - SW
) (
    input  logic [CW-1:0]    chan,
    input  logic             wide_mode,
    input  logic [BW-1:0]    part_a_blk,
    input  logic [BW-1:0]    part_b_blk,
    input  logic [CHANS-1:0] regs_flat,
    output logic             sel
);
    logic          hit_a, hit_b;
    logic [SW:0]   narrow_idx;

    always_comb begin
        hit_a      = (chan[CW-1:SW] == part_a_blk);
        hit_b      = (chan[CW-1:SW] == part_b_blk);
        narrow_idx = {~hit_a, chan[SW-1:0]};
        if (wide_mode) sel = regs_flat[chan];
        else           sel = (hit_a | hit_b) & regs_flat[narrow_idx];
    end
endmodule

// File: rtl/tx_slot_selector.sv
module tx_slot_selector #(
    parameter int NREG  = 4,
    parameter int RW    = 32,
    parameter int SUB_W = 16,
    localparam int CHANS = NREG * RW,
    localparam int CW    = $clog2(CHANS),
    localparam int AW    = $clog2(NREG),
    localparam int BW    = CW - $clog2(SUB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             word_strobe,
    input  logic [1:0]       mode,
    input  logic             wide_mode,
    input  logic [BW-1:0]    part_a_blk,
    input  logic [BW-1:0]    part_b_blk,
    input  logic [CHANS-1:0] rx_chan_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [RW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [RW-1:0]    rd_data,
    output logic [CW-1:0]    slot_num,
    output logic             tx_enable,
    output logic             tx_mask
);
    import txsel_pkg::*;

    logic [CHANS-1:0] regs_flat;
    logic             adv;
    logic [CW-1:0]    slot_nxt;
    logic             sel;
    slot_out_t        out_d, out_q;
    txm_e             mode_e;

    txsel_regbank #(.NREG(NREG), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(regs_flat)
    );

    txsel_slot_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .word_strobe(word_strobe), .adv(adv), .slot_nxt(slot_nxt),
        .slot_q(slot_num)
    );

    txsel_chan_map #(.NREG(NREG), .RW(RW), .SUB_W(SUB_W)) u_map (
        .chan(slot_nxt), .wide_mode(wide_mode), .part_a_blk(part_a_blk),
        .part_b_blk(part_b_blk), .regs_flat(regs_flat), .sel(sel)
    );

    always_comb begin
        mode_e = txm_e'(mode);
        out_d  = out_q;
        if (adv) begin
            unique case (mode_e)
                TXM_OPEN:     begin out_d.en = 1'b1;                 out_d.mask = 1'b0; end
                TXM_GATED:    begin out_d.en = sel;                  out_d.mask = ~sel; end
                TXM_MASKSEL:  begin out_d.en = 1'b1;                 out_d.mask = ~sel; end
                TXM_RXFOLLOW: begin out_d.en = rx_chan_en[slot_nxt]; out_d.mask = ~sel; end
                default:      begin out_d.en = 1'b0;                 out_d.mask = 1'b1; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{en: 1'b0, mask: 1'b1};
        else        out_q <= out_d;
    end

    assign tx_enable = out_q.en;
    assign tx_mask   = out_q.mask;
endmodule

// File: rtl/txsel_checker.sv
module txsel_checker #(
    parameter int NREG  = 4,
    parameter int RW    = 32,
    parameter int SUB_W = 16,
    localparam int CHANS = NREG * RW,
    localparam int CW    = $clog2(CHANS),
    localparam int BW    = CW - $clog2(SUB_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_sync,
    input logic             word_strobe,
    input logic [1:0]       mode,
    input logic [CHANS-1:0] rx_chan_en,
    input logic [CW-1:0]    slot_num,
    input logic             tx_enable,
    input logic             tx_mask
);
    logic          bnd;
    logic [CW-1:0] chk_nxt;
    logic          rx_at_nxt;

    always_comb begin
        bnd       = frame_sync | word_strobe;
        chk_nxt   = frame_sync ? '0 : slot_num + 1'b1;
        rx_at_nxt = rx_chan_en[chk_nxt];
    end

    p_fsync_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> slot_num == '0);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && !frame_sync) |=> slot_num == CW'($past(slot_num) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable({slot_num, tx_enable, tx_mask}));

    p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && mode == 2'd0) |=> (tx_enable && !tx_mask));

    p_gate_tie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && mode == 2'd1) |=> (tx_enable == !tx_mask));

    p_masksel_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && mode == 2'd2) |=> tx_enable);

    p_rxfollow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && mode == 2'd3) |=> (tx_enable == $past(rx_at_nxt)));
endmodule

bind tx_slot_selector txsel_checker #(.NREG(NREG), .RW(RW), .SUB_W(SUB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .word_strobe(word_strobe),
    .mode(mode), .rx_chan_en(rx_chan_en), .slot_num(slot_num),
    .tx_enable(tx_enable), .tx_mask(tx_mask)
);

// File: tb/tx_slot_selector_tb.sv
`timescale 1ns/1ps
module tx_slot_selector_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_sync = 1'b0, word_strobe = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         wide_mode = 1'b0;
    logic [2:0]   part_a_blk = 3'd0, part_b_blk = 3'd1;
    logic [127:0] rx_chan_en = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0, rd_addr = 2'd0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [6:0]   slot_num;
    logic         tx_enable, tx_mask;

    int checks = 0, errors = 0;
    logic [31:0] mreg [4];
    int   slot_m = 0;
    logic exp_en = 1'b0, exp_mask = 1'b1;
    string exp_tag = "R10";

    always #2 clk = ~clk;

    tx_slot_selector u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .word_strobe(word_strobe),
        .mode(mode), .wide_mode(wide_mode), .part_a_blk(part_a_blk),
        .part_b_blk(part_b_blk), .rx_chan_en(rx_chan_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .slot_num(slot_num), .tx_enable(tx_enable), .tx_mask(tx_mask)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic sel_m(int ch, logic w, logic [2:0] a, logic [2:0] b);
        if (w) return mreg[ch / 32][ch % 32];
        if (ch / 16 == int'(a)) return mreg[0][ch % 16];
        if (ch / 16 == int'(b)) return mreg[0][16 + ch % 16];
        return 1'b0;
    endfunction

    task automatic check_outs();
        chk({exp_tag, " slot R1"}, 32'(slot_num), 32'(slot_m));
        chk({exp_tag, " enable"}, 32'(tx_enable), 32'(exp_en));
        chk({exp_tag, " mask"}, 32'(tx_mask), 32'(exp_mask));
        chk("R9 readback", rd_data, mreg[rd_addr]);
    endtask

    task automatic step(bit fs, bit ws, logic [1:0] md, bit w, logic [2:0] a, logic [2:0] b,
                        bit we, logic [1:0] wa, logic [31:0] wd, logic [1:0] ra);
        logic s;
        frame_sync = fs; word_strobe = ws; mode = md; wide_mode = w;
        part_a_blk = a; part_b_blk = b; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        if (fs || ws) begin
            slot_m = fs ? 0 : (slot_m + 1) % 128;
            s = sel_m(slot_m, w, a, b);
            case (md)
                2'd0: begin exp_en = 1'b1;               exp_mask = 1'b0; exp_tag = "R3"; end
                2'd1: begin exp_en = s;                  exp_mask = ~s;   exp_tag = "R4"; end
                2'd2: begin exp_en = 1'b1;               exp_mask = ~s;   exp_tag = "R5"; end
                default: begin exp_en = rx_chan_en[slot_m]; exp_mask = ~s; exp_tag = "R6"; end
            endcase
            exp_tag = {exp_tag, w ? "/R7" : "/R8"};
        end else begin
            exp_tag = "R2 hold";
        end
        if (we) mreg[wa] = wd;
        @(negedge clk);
        frame_sync = 1'b0; word_strobe = 1'b0; wr_en = 1'b0;
        check_outs();
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R9 reset value of registers
        chk("R10 slot", 32'(slot_num), 0);
        chk("R10 enable", 32'(tx_enable), 0);
        chk("R10 mask", 32'(tx_mask), 1);
        for (int i = 0; i < 4; i++) begin
            rd_addr = 2'(i); #1;
            chk("R9 reset value", rd_data, 32'h0);
        end
        @(negedge clk);
        // R9 write all registers, read back
        for (int i = 0; i < 4; i++)
            step(0, 0, 2'd1, 1, 3'd0, 3'd1, 1, 2'(i), 32'hA5C3_0F00 ^ (32'(i) * 32'h1111_1111), 2'(i));
        // R3 mode 0 ignores registers: clear all, still open
        for (int i = 0; i < 4; i++) step(0, 0, 2'd0, 1, 3'd0, 3'd1, 1, 2'(i), 32'h0, 2'(i));
        step(1, 0, 2'd0, 1, 3'd0, 3'd1, 0, 2'd0, 32'h0, 2'd0);
        step(0, 1, 2'd0, 0, 3'd7, 3'd7, 0, 2'd0, 32'h0, 2'd0);
        // R2 write in the same cycle as a boundary: old value used
        step(1, 0, 2'd1, 1, 3'd0, 3'd1, 1, 2'd0, 32'hFFFF_FFFF, 2'd0);
        // next boundary sees it
        step(0, 1, 2'd1, 1, 3'd0, 3'd1, 0, 2'd0, 32'h0, 2'd0);
        // R2 mid-slot write, outputs hold
        step(0, 0, 2'd1, 1, 3'd0, 3'd1, 1, 2'd0, 32'h0, 2'd0);
        // R8 blocks missing the channel, and equal blocks
        step(0, 0, 2'd1, 0, 3'd5, 3'd6, 1, 2'd0, 32'hFFFF_FFFF, 2'd0);
        step(1, 0, 2'd1, 0, 3'd5, 3'd6, 0, 2'd0, 32'h0, 2'd0);
        step(0, 0, 2'd1, 0, 3'd0, 3'd0, 1, 2'd0, 32'h0000_FFFF, 2'd0);
        step(0, 1, 2'd2, 0, 3'd0, 3'd0, 0, 2'd0, 32'h0, 2'd0);
        // R1 walk whole frame and wrap, with strobe plus sync at the end
        for (int i = 0; i < 130; i++)
            step(0, 1, 2'(i % 4), 1'(i % 2), 3'(i % 8), 3'((i + 3) % 8), 0, 2'd0, 32'h0, 2'(i % 4));
        step(1, 1, 2'd2, 1, 3'd0, 3'd1, 0, 2'd0, 32'h0, 2'd0);
        // R6 receive and transmit bits disagree
        rx_chan_en = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        step(0, 0, 2'd3, 1, 3'd0, 3'd1, 1, 2'd0, 32'h0000_0000, 2'd0);
        step(0, 1, 2'd3, 1, 3'd0, 3'd1, 0, 2'd0, 32'h0, 2'd0);
        for (int i = 0; i < 4000; i++) begin
            rx_chan_en = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom % 20) == 0, ($urandom % 2) == 0, 2'($urandom), 1'($urandom),
                 3'($urandom), 3'($urandom), ($urandom % 4) == 0, 2'($urandom),
                 $urandom, 2'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule